// File: doc/BRIEF.md
# Configuration Memory Front End with Serial EEPROM Shadowing

This block sits between a host register bus, an external byte-wide serial EEPROM and the configuration registers of a sensor interface device. After reset it reads the first sixteen EEPROM bytes in ascending order and places them in the sixteen configuration registers. While this load runs, the host bus refuses every request. If the EEPROM does not answer the very first read within a fixed number of cycles, the block records that no memory is fitted, keeps the reset defaults and gives the host control at once.

Once the load is done, host addresses 0 to 15 reach the registers directly. Addresses 16 to 127 are forwarded to the EEPROM with sixteen subtracted, so EEPROM bytes 0 to 111 fill that window. When no EEPROM is fitted, the host sets the device up by writing the registers and writes register 0 last. That write raises a configuration-valid flag which enables the rest of the chip. In this case the upper window only answers reads of addresses 120 to 127, which return identification bytes. Address 124 in that range mirrors register 0.

Both external ports use a level request held until a one-cycle answer. The EEPROM port takes requests on `ee_req` and answers with `ee_ack`. The host port is answered by exactly one pulse of `h_ack` or `h_nak`.

Top module: `cfg_mem_front`

## Requirements
- R1: While reset is asserted, every register output equals RST_VAL, `cfg_valid` is 0, `busy` is 1 and the EEPROM port requests a read (`ee_we` = 0) of EEPROM address 0.
- R2: With an EEPROM present, EEPROM bytes 0..15 are read in ascending address order and end up in registers 0..15 (register k at `cfg_regs[8k+7:8k]`). `busy` falls only after the last byte is stored.
- R3: Every host request seen while `busy` is 1 is answered with `h_nak` and has no effect.
- R4: If the read of EEPROM byte 0 is not acknowledged within TIMEOUT cycles, the EEPROM is taken as absent. `busy` falls and all registers keep RST_VAL.
- R5: With an EEPROM present, a host access to address A in 16..127 becomes one EEPROM access to address A-16 with the same direction and write data. The host is answered with `h_ack` after the EEPROM acknowledge, and a read returns the EEPROM byte on `h_rdata`.
- R6: A host read of address 0..15 returns that register on `h_rdata` with `h_ack` and makes no EEPROM access.
- R7: With an EEPROM present, a host write to address k in 0..15 updates register k and writes EEPROM byte k with the same value before `h_ack`.
- R8: With the EEPROM absent, a host write to 0..15 updates the register and is acknowledged without any EEPROM request after the load phase.
- R9: With the EEPROM absent, every access to 16..119 and every write to 120..127 is answered with `h_nak` and changes nothing.
- R10: With the EEPROM absent, a read of address 120+n returns byte n of DEV_ID (bits 8n+7:8n) for n other than 4. A read of address 124 returns register 0.
- R11: `cfg_valid` rises when a present EEPROM finishes loading or when the host writes register 0, and stays high until reset.
- R12: Each host request receives exactly one one-cycle pulse of either `h_ack` or `h_nak`, never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ee_req | output | 1 | EEPROM access request, held until acknowledged |
| ee_we | output | 1 | EEPROM access is a write |
| ee_addr | output | 7 | EEPROM byte address |
| ee_wdata | output | 8 | EEPROM write data |
| ee_ack | input | 1 | EEPROM acknowledge, one cycle |
| ee_rdata | input | 8 | EEPROM read data, valid with `ee_ack` |
| h_req | input | 1 | Host request, held until answered |
| h_we | input | 1 | Host request is a write |
| h_addr | input | 7 | Host register address |
| h_wdata | input | 8 | Host write data |
| h_ack | output | 1 | Host request completed |
| h_nak | output | 1 | Host request refused |
| h_rdata | output | 8 | Host read data, valid with `h_ack` |
| busy | output | 1 | Power-up load in progress |
| cfg_valid | output | 1 | Configuration complete flag |
| cfg_regs | output | 128 | Sixteen configuration registers, register k in bits 8k+7:8k |

## Verification
The bench sweeps every host address in both the present and the absent configuration, so the 15/16 and 119/120 window edges are exercised. A wrong offset would show up as a shifted EEPROM byte, and a wrong upper bound would return data where a refusal is expected. Mirror slot 124 and the identification bytes are compared one by one, which catches a mirror placed on the wrong address or bytes read in the wrong order. The bench also checks that `cfg_valid` stays low until register 0 is written last, and that a register write reaches the EEPROM only when one is fitted. A requester polled during the load or timeout window must be refused; a design that answers early would acknowledge with stale defaults.

// File: rtl/cfgm_pkg.sv
package cfgm_pkg;
  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_IDLE = 2'd1,
    ST_XFER = 2'd2
  } cfgm_state_t;
endpackage

// File: rtl/cfgm_regfile.sv
module cfgm_regfile #(
  parameter int NREGS = 16,
  parameter int DW = 8,
  parameter logic [7:0] RST_VAL = 8'h00,
  localparam int RIW = $clog2(NREGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [RIW-1:0]     wr_idx,
  input  logic [DW-1:0]      wr_data,
  input  logic               set_valid,
  output logic [NREGS*DW-1:0] regs_flat,
  output logic               valid
);
  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [DW-1:0] q;
    logic          en;
    assign en = wr_en && (wr_idx == RIW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= DW'(RST_VAL);
      else if (en) q <= wr_data;
    end
    assign regs_flat[g*DW +: DW] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         valid <= 1'b0;
    else if (set_valid) valid <= 1'b1;
  end
endmodule

// File: rtl/cfgm_idmap.sv
module cfgm_idmap #(
  parameter int DW = 8,
  parameter logic [63:0] DEV_ID = 64'h5A3C_96E1_0F72_C4B8,
  parameter int MIRROR_SLOT = 4
) (
  input  logic [2:0]    sel,
  input  logic [DW-1:0] reg0,
  output logic [DW-1:0] data
);
  always_comb begin
    if (sel == 3'(MIRROR_SLOT)) data = reg0;
    else                        data = DEV_ID[sel*8 +: 8];
  end
endmodule

// File: rtl/cfgm_ctrl.sv
module cfgm_ctrl
  import cfgm_pkg::*;
#(
  parameter int NREGS = 16,
  parameter int DW = 8,
  parameter int HAW = 7,
  parameter int TIMEOUT = 24,
  localparam int RIW = $clog2(NREGS),
  localparam int TW = $clog2(TIMEOUT + 1),
  localparam logic [HAW-1:0] OFS = HAW'(NREGS),
  localparam logic [HAW-1:0] ID_BASE = HAW'((1 << HAW) - 8)
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic           ee_req,
  output logic           ee_we,
  output logic [HAW-1:0] ee_addr,
  output logic [DW-1:0]  ee_wdata,
  input  logic           ee_ack,
  input  logic [DW-1:0]  ee_rdata,
  input  logic           h_req,
  input  logic           h_we,
  input  logic [HAW-1:0] h_addr,
  input  logic [DW-1:0]  h_wdata,
  output logic           h_ack,
  output logic           h_nak,
  output logic [DW-1:0]  h_rdata,
  input  logic [DW-1:0]  reg_rd,
  input  logic [DW-1:0]  id_rd,
  output logic           reg_we,
  output logic [RIW-1:0] reg_idx,
  output logic [DW-1:0]  reg_wdata,
  output logic           set_valid,
  output logic           busy,
  output logic           present
);
  cfgm_state_t st_q, st_d;
  logic [RIW-1:0] idx_q, idx_d;
  logic [TW-1:0]  tmo_q, tmo_d;
  logic           pres_d;
  logic           opwe_q, opwe_d;
  logic [HAW-1:0] opa_q, opa_d;
  logic [DW-1:0]  opd_q, opd_d;
  logic           ack_d, nak_d;
  logic [DW-1:0]  rd_d;
  logic           new_req;

  assign new_req  = h_req && !h_ack && !h_nak;
  assign busy     = (st_q == ST_LOAD);
  assign ee_req   = (st_q != ST_IDLE);
  assign ee_we    = (st_q == ST_XFER) && opwe_q;
  assign ee_addr  = (st_q == ST_LOAD) ? HAW'(idx_q) : opa_q;
  assign ee_wdata = opd_q;

  always_comb begin
    st_d = st_q; idx_d = idx_q; tmo_d = tmo_q; pres_d = present;
    opwe_d = opwe_q; opa_d = opa_q; opd_d = opd_q;
    ack_d = 1'b0; nak_d = 1'b0; rd_d = h_rdata;
    reg_we = 1'b0; reg_idx = h_addr[RIW-1:0]; reg_wdata = h_wdata; set_valid = 1'b0;
    case (st_q)
      ST_LOAD: begin
        reg_idx   = idx_q;
        reg_wdata = ee_rdata;
        nak_d     = new_req;
        if (ee_ack) begin
          reg_we = 1'b1;
          if (idx_q == RIW'(NREGS - 1)) begin
            st_d = ST_IDLE; pres_d = 1'b1; set_valid = 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end else if (idx_q == '0) begin
          if (tmo_q == TW'(TIMEOUT - 1)) begin
            st_d = ST_IDLE; pres_d = 1'b0;
          end else begin
            tmo_d = tmo_q + 1'b1;
          end
        end
      end
      ST_IDLE: begin
        if (new_req) begin
          if (h_addr < OFS) begin
            if (h_we) begin
              reg_we = 1'b1;
              set_valid = (h_addr == '0);
              if (present) begin
                st_d = ST_XFER; opwe_d = 1'b1; opa_d = h_addr; opd_d = h_wdata;
              end else begin
                ack_d = 1'b1;
              end
            end else begin
              ack_d = 1'b1; rd_d = reg_rd;
            end
          end else if (present) begin
            st_d = ST_XFER; opwe_d = h_we; opa_d = h_addr - OFS; opd_d = h_wdata;
          end else if (!h_we && h_addr >= ID_BASE) begin
            ack_d = 1'b1; rd_d = id_rd;
          end else begin
            nak_d = 1'b1;
          end
        end
      end
      default: begin
        if (ee_ack) begin
          st_d  = ST_IDLE;
          ack_d = 1'b1;
          if (!opwe_q) rd_d = ee_rdata;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_LOAD; idx_q <= '0; tmo_q <= '0; present <= 1'b0;
      opwe_q <= 1'b0; opa_q <= '0; opd_q <= '0;
      h_ack <= 1'b0; h_nak <= 1'b0; h_rdata <= '0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; tmo_q <= tmo_d; present <= pres_d;
      opwe_q <= opwe_d; opa_q <= opa_d; opd_q <= opd_d;
      h_ack <= ack_d; h_nak <= nak_d; h_rdata <= rd_d;
    end
  end
endmodule

// File: rtl/cfg_mem_front.sv
module cfg_mem_front #(
  parameter int NREGS = 16,
  parameter int DW = 8,
  parameter int HAW = 7,
  parameter int TIMEOUT = 24,
  parameter logic [63:0] DEV_ID = 64'h5A3C_96E1_0F72_C4B8,
  parameter logic [7:0] RST_VAL = 8'h00,
  localparam int RIW = $clog2(NREGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                ee_req,
  output logic                ee_we,
  output logic [HAW-1:0]      ee_addr,
  output logic [DW-1:0]       ee_wdata,
  input  logic                ee_ack,
  input  logic [DW-1:0]       ee_rdata,
  input  logic                h_req,
  input  logic                h_we,
  input  logic [HAW-1:0]      h_addr,
  input  logic [DW-1:0]       h_wdata,
  output logic                h_ack,
  output logic                h_nak,
  output logic [DW-1:0]       h_rdata,
  output logic                busy,
  output logic                cfg_valid,
  output logic [NREGS*DW-1:0] cfg_regs
);
  logic [1:0]     rst_pipe;
  logic           rst_n_s;
  logic           reg_we, set_valid, ee_present;
  logic [RIW-1:0] reg_idx;
  logic [DW-1:0]  reg_wdata, reg_rd, id_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  assign reg_rd = cfg_regs[h_addr[RIW-1:0]*DW +: DW];

  cfgm_regfile #(.NREGS(NREGS), .DW(DW), .RST_VAL(RST_VAL)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(reg_we), .wr_idx(reg_idx),
    .wr_data(reg_wdata), .set_valid(set_valid), .regs_flat(cfg_regs), .valid(cfg_valid)
  );

  cfgm_idmap #(.DW(DW), .DEV_ID(DEV_ID), .MIRROR_SLOT(4)) u_id (
    .sel(h_addr[2:0]), .reg0(cfg_regs[DW-1:0]), .data(id_rd)
  );

  cfgm_ctrl #(.NREGS(NREGS), .DW(DW), .HAW(HAW), .TIMEOUT(TIMEOUT)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s),
    .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
    .ee_ack(ee_ack), .ee_rdata(ee_rdata),
    .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_ack(h_ack), .h_nak(h_nak), .h_rdata(h_rdata),
    .reg_rd(reg_rd), .id_rd(id_rd),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .set_valid(set_valid),
    .busy(busy), .present(ee_present)
  );
endmodule

// File: rtl/cfgm_chk.sv
module cfgm_chk #(
  parameter int HAW = 7,
  parameter int EE_BYTES = 112
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ee_req,
  input logic           ee_we,
  input logic [HAW-1:0] ee_addr,
  input logic           ee_ack,
  input logic           h_ack,
  input logic           h_nak,
  input logic           busy,
  input logic           present,
  input logic           cfg_valid
);
  p_one_answer_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_ack && h_nak));
  p_ack_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    h_ack |=> !h_ack);
  p_nak_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    h_nak |=> !h_nak);
  p_refuse_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !h_ack);
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_req && !ee_ack && !busy) |=> (ee_req && $stable(ee_addr) && $stable(ee_we)));
  p_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req |-> (ee_addr < HAW'(EE_BYTES)));
  p_absent_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !present) |-> !ee_req);
  p_valid_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> cfg_valid);
endmodule

bind cfg_mem_front cfgm_chk #(.HAW(HAW), .EE_BYTES((1 << HAW) - NREGS)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr),
  .ee_ack(ee_ack), .h_ack(h_ack), .h_nak(h_nak), .busy(busy),
  .present(ee_present), .cfg_valid(cfg_valid)
);

// File: tb/cfg_mem_front_tb_top.sv
module cfg_mem_front_tb_top;
  localparam logic [63:0] DEV_ID = 64'h5A3C_96E1_0F72_C4B8;
  localparam int TIMEOUT = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ee_req, ee_we, ee_ack;
  logic [6:0] ee_addr;
  logic [7:0] ee_wdata, ee_rdata;
  logic h_req = 1'b0, h_we = 1'b0;
  logic [6:0] h_addr = '0;
  logic [7:0] h_wdata = '0;
  logic h_ack, h_nak, busy, cfg_valid;
  logic [7:0] h_rdata;
  logic [127:0] cfg_regs;

  logic ee_on = 1'b1;
  logic [7:0] mem [112];
  int n_cmp = 0, n_bad = 0, ee_hits = 0, cyc = 0;

  always #4 clk = ~clk;

  cfg_mem_front #(.TIMEOUT(TIMEOUT), .DEV_ID(DEV_ID)) dut_i (
    .clk(clk), .rst_n(rst_n), .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr),
    .ee_wdata(ee_wdata), .ee_ack(ee_ack), .ee_rdata(ee_rdata),
    .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_ack(h_ack), .h_nak(h_nak), .h_rdata(h_rdata),
    .busy(busy), .cfg_valid(cfg_valid), .cfg_regs(cfg_regs)
  );

  function automatic logic [7:0] seed(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ee_ack <= 1'b0; ee_rdata <= '0;
      for (int i = 0; i < 112; i++) mem[i] <= seed(i);
    end else if (!ee_on) begin
      ee_ack <= 1'b0;
    end else begin
      ee_ack <= ee_req && !ee_ack;
      if (ee_req && !ee_ack && ee_addr < 7'd112) begin
        ee_rdata <= mem[ee_addr];
        if (ee_we) mem[ee_addr] <= ee_wdata;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && ee_req && ee_ack && !busy) ee_hits <= ee_hits + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    forever begin
      @(negedge clk);
      if (cyc > 100000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        finish_run();
      end
    end
  end

  // Returns 1 for ack, 2 for nak, 0 for no answer
  task automatic access(input bit we, input int addr, input int wd,
                        output int resp, output int rd);
    int t = 0;
    @(negedge clk);
    h_req = 1'b1; h_we = we; h_addr = 7'(addr); h_wdata = 8'(wd);
    resp = 0; rd = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!h_ack && !h_nak && t < 200);
    if (h_ack && h_nak) resp = 3;
    else if (h_ack) resp = 1;
    else if (h_nak) resp = 2;
    rd = int'(h_rdata);
    h_req = 1'b0;
    @(negedge clk);
    check(!h_ack && !h_nak, "R12", int'({h_ack, h_nak}), 0);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(cfg_valid == 1'b0 && busy == 1'b1, "R1", int'({cfg_valid, busy}), 1);
    check(cfg_regs == '0, "R1", int'(cfg_regs[31:0]), 0);
    check(ee_req && !ee_we && ee_addr == 7'd0, "R1", int'({ee_req, ee_we, ee_addr}), 'h100);
    rst_n = 1'b1;
  endtask

  initial begin
    int resp, rd, base;
    // Present EEPROM
    ee_on = 1'b1;
    apply_reset();
    repeat (3) @(negedge clk);
    access(1'b0, 5, 0, resp, rd);
    check(resp == 2, "R3", resp, 2);
    while (busy) @(negedge clk);
    for (int k = 0; k < 16; k++)
      check(cfg_regs[k*8 +: 8] == seed(k), "R2", int'(cfg_regs[k*8 +: 8]), int'(seed(k)));
    check(cfg_valid == 1'b1, "R11", int'(cfg_valid), 1);
    for (int a = 16; a < 128; a++) begin
      access(1'b0, a, 0, resp, rd);
      check(resp == 1 && rd == int'(mem[a-16]), "R5", rd, int'(mem[a-16]));
    end
    base = ee_hits;
    for (int k = 0; k < 16; k++) begin
      access(1'b0, k, 0, resp, rd);
      check(resp == 1 && rd == int'(seed(k)), "R6", rd, int'(seed(k)));
    end
    check(ee_hits == base, "R6", ee_hits, base);
    access(1'b1, 40, 'hA5, resp, rd);
    check(resp == 1 && mem[24] == 8'hA5, "R5", int'(mem[24]), 'hA5);
    access(1'b0, 40, 0, resp, rd);
    check(rd == 'hA5, "R5", rd, 'hA5);
    access(1'b1, 3, 'h3C, resp, rd);
    check(resp == 1 && cfg_regs[31:24] == 8'h3C, "R7", int'(cfg_regs[31:24]), 'h3C);
    check(mem[3] == 8'h3C, "R7", int'(mem[3]), 'h3C);
    access(1'b0, 127, 0, resp, rd);
    check(rd == int'(seed(111)), "R5", rd, int'(seed(111)));

    // Absent EEPROM
    ee_on = 1'b0;
    apply_reset();
    repeat (TIMEOUT / 2) @(negedge clk);
    check(busy == 1'b1, "R4", int'(busy), 1);
    access(1'b1, 2, 'h11, resp, rd);
    check(resp == 2, "R3", resp, 2);
    repeat (TIMEOUT + 4) @(negedge clk);
    check(busy == 1'b0, "R4", int'(busy), 0);
    check(cfg_regs == '0 && cfg_valid == 1'b0, "R4", int'(cfg_regs[31:0]), 0);
    base = ee_hits;
    for (int k = 15; k >= 1; k--) begin
      access(1'b1, k, k * 9 + 1, resp, rd);
      check(resp == 1 && cfg_regs[k*8 +: 8] == 8'(k * 9 + 1), "R8",
            int'(cfg_regs[k*8 +: 8]), k * 9 + 1);
    end
    check(cfg_valid == 1'b0, "R11", int'(cfg_valid), 0);
    access(1'b1, 0, 'h77, resp, rd);
    check(resp == 1 && cfg_valid == 1'b1, "R11", int'(cfg_valid), 1);
    check(ee_hits == base && !ee_req, "R8", ee_hits, base);
    for (int a = 16; a < 128; a++) begin
      access(1'b0, a, 0, resp, rd);
      if (a < 120) check(resp == 2, "R9", resp, 2);
      else if (a == 124) check(resp == 1 && rd == 'h77, "R10", rd, 'h77);
      else check(resp == 1 && rd == int'(DEV_ID[(a-120)*8 +: 8]), "R10",
                 rd, int'(DEV_ID[(a-120)*8 +: 8]));
    end
    access(1'b1, 16, 'h55, resp, rd);
    check(resp == 2, "R9", resp, 2);
    access(1'b1, 119, 'h55, resp, rd);
    check(resp == 2, "R9", resp, 2);
    access(1'b1, 124, 'h55, resp, rd);
    check(resp == 2, "R9", resp, 2);
    access(1'b0, 124, 0, resp, rd);
    check(rd == 'h77 && cfg_regs[7:0] == 8'h77, "R9", rd, 'h77);
    access(1'b0, 121, 0, resp, rd);
    check(rd == int'(DEV_ID[15:8]), "R10", rd, int'(DEV_ID[15:8]));
    finish_run();
  end
endmodule